// File: doc/BRIEF.md
# Global-History Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It keeps a table of two-bit saturating confidence counters, and a shift register that records recent branch outcomes. Fetch presents a program counter. The block forms a table index by XORing a slice of the PC with the outcome history, and returns the direction stored at that index together with the index itself. Fetch carries the index along with the branch.

When the branch executes, the pipeline hands back the stored index and the real outcome. The addressed counter moves one step toward the observed direction, and the outcome enters the history. The table has no tags, so two branches that map to the same index share one counter. Because the history takes part in the index, the same branch reaches different counters in different contexts. A short repeating pattern, such as a loop that runs six times and then exits, therefore becomes fully predictable once trained.

Top module: `ghist_dir_pred`

## Requirements
- R1: After a synchronous active-low reset, every counter holds weakly not-taken (code 00) and the history register is zero. Every PC then predicts not-taken, and `pred_idx` equals PC bits 8:2.
- R2: `pred_idx` equals PC bits 8:2 XOR the 7-bit history register. The history register holds the most recent outcome in bit 0.
- R3: `pred_taken` is bit 1 of the counter selected by `pred_idx`. Codes 10 and 11 predict taken. Codes 00 and 01 predict not-taken.
- R4: A taken resolve moves the addressed counter along 01 → 00 → 10 → 11 and leaves it at 11 once it is there.
- R5: A not-taken resolve moves the addressed counter along 11 → 10 → 00 → 01 and leaves it at 01 once it is there.
- R6: Each resolve shifts the history left by one. The outcome (1 = taken) enters bit 0 and the oldest bit is dropped.
- R7: A resolve changes only the counter at `res_idx`. Every other counter keeps its value.
- R8: When a predict and a resolve address the same counter in one cycle, the prediction reflects the value from before the update.
- R9: The table has no tags. Two PCs that produce the same index read and train the same counter.
- R10: After training, a single branch whose outcomes repeat as six takens then one not-taken is predicted with no mispredictions.
- R11: While `res_valid` is low, neither the counters nor the history change, whatever `res_idx` and `res_taken` carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| pred_pc | input | PC_W | PC of the branch being fetched |
| pred_taken | output | 1 | Predicted direction, 1 = taken |
| pred_idx | output | IDX_W | Table index used for this prediction |
| res_valid | input | 1 | A resolved branch is presented this cycle |
| res_idx | input | IDX_W | Index that was returned when the branch was predicted |
| res_taken | input | 1 | Real outcome, 1 = taken |

## Verification
The assertions check the following on every cycle:
- the history shift and the history hold with no resolve;
- the one-step counter move in each direction, including saturation;
- that a neighbouring counter is untouched by an update;
- that the prediction matches the addressed counter's upper bit;
- the cleared state on leaving reset.

Only the bench scenarios can show the outcomes that depend on a sequence of events:
- index formation against a reference history;
- a counter walked across its whole range, with saturation made visible through the later predictions;
- the pre-update read in a cycle where predict and resolve collide;
- two aliased PCs sharing one counter;
- perfect prediction of the seven-long loop pattern after training.

// File: rtl/dpred_pkg.sv
// Package: shared counter type and helpers for the direction predictor.
// Assumes the code set SNT=01, WNT=00, WT=10, ST=11; bit 1 is the direction.
package dpred_pkg;

    typedef enum logic [1:0] {
        CTR_WNT = 2'b00,
        CTR_SNT = 2'b01,
        CTR_WT  = 2'b10,
        CTR_ST  = 2'b11
    } ctr_e;

    // Next counter state after one resolved outcome (saturating).
    function automatic ctr_e ctr_next(input ctr_e cur, input logic taken);
        ctr_e nxt;
        case (cur)
            CTR_SNT: nxt = taken ? CTR_WNT : CTR_SNT;
            CTR_WNT: nxt = taken ? CTR_WT  : CTR_SNT;
            CTR_WT:  nxt = taken ? CTR_ST  : CTR_WNT;
            default: nxt = taken ? CTR_ST  : CTR_WT;
        endcase
        return nxt;
    endfunction

    // Confidence rank 0..3 from strongly not-taken to strongly taken.
    function automatic logic [1:0] ctr_rank(input logic [1:0] code);
        return {code[1], ~(code[1] ^ code[0])};
    endfunction

endpackage

// File: rtl/dpred_index.sv
// Module: dpred_index
// Forms the table index from the PC slice and the outcome history.
// Assumes history bits beyond IDX_W fold back onto the index modulo IDX_W.
module dpred_index #(
    parameter int IDX_W  = 7,
    parameter int HIST_W = 7
) (
    input  logic [IDX_W-1:0]  pc_slice,
    input  logic [HIST_W-1:0] hist,
    output logic [IDX_W-1:0]  idx
);

    // Fold every history bit into the PC slice with XOR.
    always_comb begin
        idx = pc_slice;
        for (int i = 0; i < HIST_W; i++) begin
            idx[i % IDX_W] = idx[i % IDX_W] ^ hist[i];
        end
    end

endmodule

// File: rtl/dpred_history.sv
// Module: dpred_history
// Global outcome shift register; newest outcome in bit 0.
// Assumes shifts happen only on resolved branches.
module dpred_history #(
    parameter int HIST_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic              bit_in,
    output logic [HIST_W-1:0] hist
);

    generate
        if (HIST_W == 1) begin : g_one
            // Single-bit history simply holds the last outcome.
            always_ff @(posedge clk) begin
                if (!rst_n)        hist <= '0;
                else if (shift_en) hist <= bit_in;
            end
        end else begin : g_multi
            // Shift the new outcome into bit 0, dropping the oldest.
            always_ff @(posedge clk) begin
                if (!rst_n)        hist <= '0;
                else if (shift_en) hist <= {hist[HIST_W-2:0], bit_in};
            end
        end
    endgenerate

endmodule

// File: rtl/dpred_ctr_table.sv
// Module: dpred_ctr_table
// Untagged table of 2-bit saturating counters, one read and one update port.
// Assumes the read is combinational from the stored state, so a same-cycle
// update is seen only after the clock edge.
module dpred_ctr_table
    import dpred_pkg::*;
#(
    parameter int IDX_W = 7,
    localparam int DEPTH = 1 << IDX_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [IDX_W-1:0]      rd_idx,
    output logic [1:0]            rd_ctr,
    input  logic                  wr_en,
    input  logic [IDX_W-1:0]      wr_idx,
    input  logic                  wr_taken,
    output logic [DEPTH-1:0][1:0] all_ctr
);

    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_ent
            ctr_e ent_q;
            // Step this entry when the update addresses it.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    ent_q <= CTR_WNT;
                else if (wr_en && (wr_idx == IDX_W'(g)))
                    ent_q <= ctr_next(ent_q, wr_taken);
            end
            assign all_ctr[g] = ent_q;
        end
    endgenerate

    // Read port: select the addressed counter.
    assign rd_ctr = all_ctr[rd_idx];

endmodule

// File: rtl/ghist_dir_pred.sv
// Module: ghist_dir_pred (top)
// Direction predictor: PC slice XOR global history indexes a counter table.
// Assumes the caller returns the predict-time index on resolve.
module ghist_dir_pred #(
    parameter int PC_W   = 32,
    parameter int IDX_W  = 7,
    parameter int HIST_W = 7,
    parameter int PC_LSB = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PC_W-1:0]  pred_pc,
    output logic             pred_taken,
    output logic [IDX_W-1:0] pred_idx,
    input  logic             res_valid,
    input  logic [IDX_W-1:0] res_idx,
    input  logic             res_taken
);

    localparam int DEPTH = 1 << IDX_W;

    logic [HIST_W-1:0]     ghist;
    logic [IDX_W-1:0]      pc_slice;
    logic [1:0]            rd_ctr;
    logic [DEPTH-1:0][1:0] ctr_flat;

    // Select the PC bits that feed the index.
    assign pc_slice = pred_pc[PC_LSB +: IDX_W];

    dpred_index #(.IDX_W(IDX_W), .HIST_W(HIST_W)) u_index (
        .pc_slice (pc_slice),
        .hist     (ghist),
        .idx      (pred_idx)
    );

    dpred_history #(.HIST_W(HIST_W)) u_hist (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (res_valid),
        .bit_in   (res_taken),
        .hist     (ghist)
    );

    dpred_ctr_table #(.IDX_W(IDX_W)) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (pred_idx),
        .rd_ctr   (rd_ctr),
        .wr_en    (res_valid),
        .wr_idx   (res_idx),
        .wr_taken (res_taken),
        .all_ctr  (ctr_flat)
    );

    // Direction is the upper bit of the selected counter.
    assign pred_taken = rd_ctr[1];

endmodule

// File: rtl/ghist_dir_pred_chk.sv
// Module: ghist_dir_pred_chk
// Cycle-level properties of the predictor, bound onto the top module.
module ghist_dir_pred_chk
    import dpred_pkg::*;
#(
    parameter int IDX_W  = 7,
    parameter int HIST_W = 7,
    localparam int DEPTH = 1 << IDX_W
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  res_valid,
    input logic [IDX_W-1:0]      res_idx,
    input logic                  res_taken,
    input logic [IDX_W-1:0]      pred_idx,
    input logic                  pred_taken,
    input logic [HIST_W-1:0]     ghist,
    input logic [DEPTH-1:0][1:0] ctr_flat
);

    p_reset_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (ghist == '0 && !pred_taken));

    p_pred_msb_r3: assert property (@(posedge clk) disable iff (!rst_n)
        pred_taken == ctr_flat[pred_idx][1]);

    p_step_up_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_taken) |=>
        ctr_rank(ctr_flat[$past(res_idx)]) ==
        (($past(ctr_rank(ctr_flat[res_idx])) == 2'd3) ? 2'd3
                                                       : $past(ctr_rank(ctr_flat[res_idx])) + 2'd1));

    p_step_down_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_taken) |=>
        ctr_rank(ctr_flat[$past(res_idx)]) ==
        (($past(ctr_rank(ctr_flat[res_idx])) == 2'd0) ? 2'd0
                                                       : $past(ctr_rank(ctr_flat[res_idx])) - 2'd1));

    p_hist_shift_r6: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> (ghist[0] == $past(res_taken)) &&
                      (ghist >> 1) == ($past(ghist) & {1'b0, {(HIST_W-1){1'b1}}}));

    p_neighbor_kept_r7: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> ctr_flat[$past(res_idx) ^ IDX_W'(1)] == $past(ctr_flat[res_idx ^ IDX_W'(1)]));

    p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |=> ($stable(ghist) && $stable(ctr_flat)));

endmodule

bind ghist_dir_pred ghist_dir_pred_chk #(.IDX_W(IDX_W), .HIST_W(HIST_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .res_valid  (res_valid),
    .res_idx    (res_idx),
    .res_taken  (res_taken),
    .pred_idx   (pred_idx),
    .pred_taken (pred_taken),
    .ghist      (ghist),
    .ctr_flat   (ctr_flat)
);

// File: tb/test_ghist_dir_pred.sv
`timescale 1ns/1ps
module test_ghist_dir_pred;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] pred_pc = '0;
    logic        pred_taken;
    logic [6:0]  pred_idx;
    logic        res_valid = 1'b0;
    logic [6:0]  res_idx = '0;
    logic        res_taken = 1'b0;

    int n_chk = 0;
    int n_bad = 0;

    logic [1:0] m_ctr [128];
    logic [6:0] m_hist;

    always #5 clk = ~clk;

    ghist_dir_pred i_ghist_dir_pred (
        .clk(clk), .rst_n(rst_n), .pred_pc(pred_pc), .pred_taken(pred_taken),
        .pred_idx(pred_idx), .res_valid(res_valid), .res_idx(res_idx), .res_taken(res_taken)
    );

    // Reference step: rank order SNT(01) < WNT(00) < WT(10) < ST(11).
    function automatic logic [1:0] m_step(input logic [1:0] c, input bit tk);
        logic [1:0] ord [4];
        int r;
        ord[0] = 2'b01; ord[1] = 2'b00; ord[2] = 2'b10; ord[3] = 2'b11;
        r = 0;
        for (int k = 0; k < 4; k++) if (ord[k] == c) r = k;
        if (tk) r = (r == 3) ? 3 : r + 1;
        else    r = (r == 0) ? 0 : r - 1;
        return ord[r];
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [31:0] pc_for(input logic [6:0] ent);
        return {23'd0, ent ^ m_hist, 2'b00};
    endfunction

    // One cycle: predict at pc, optionally resolve that prediction.
    task automatic step(input logic [31:0] pc, input bit rv, input bit tk, output bit pr);
        logic [6:0] eidx;
        @(negedge clk);
        pred_pc = pc; res_valid = 1'b0;
        #1;
        eidx = pc[8:2] ^ m_hist;
        chk(pred_idx == eidx, "R2", pred_idx, eidx);
        chk(pred_taken == m_ctr[eidx][1], "R3", pred_taken, m_ctr[eidx][1]);
        pr = pred_taken;
        res_valid = rv; res_idx = pred_idx; res_taken = tk;
        #1;
        chk(pred_taken == pr, "R8", pred_taken, pr);
        @(posedge clk);
        if (rv) begin
            m_ctr[eidx] = m_step(m_ctr[eidx], tk);
            m_hist = {m_hist[5:0], tk};
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; res_valid = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 128; i++) m_ctr[i] = 2'b00;
        m_hist = '0;
    endtask

    task automatic t_reset();
        bit pr;
        do_reset();
        for (int e = 0; e < 128; e++) begin
            step({23'd0, 7'(e), 2'b00}, 1'b0, 1'b0, pr);
            chk(pr == 1'b0, "R1", pr, 0);
            chk(pred_idx == 7'(e), "R1", pred_idx, e);
        end
    endtask

    task automatic t_walk();
        bit seq [10];
        bit expp [10];
        bit pr;
        seq  = '{0,0,1,1,1,1,0,0,0,1};
        expp = '{0,0,0,0,1,1,1,1,0,0};
        do_reset();
        for (int s = 0; s < 10; s++) begin
            step(pc_for(7'd5), 1'b1, seq[s], pr);
            if (seq[s]) chk(pr == expp[s], "R4", pr, expp[s]);
            else        chk(pr == expp[s], "R5", pr, expp[s]);
        end
    endtask

    task automatic t_neighbor();
        bit pr;
        do_reset();
        step(pc_for(7'd9), 1'b1, 1'b1, pr);
        step(pc_for(7'd8), 1'b0, 1'b0, pr);
        chk(pr == 1'b0, "R7", pr, 0);
        step(pc_for(7'd10), 1'b0, 1'b0, pr);
        chk(pr == 1'b0, "R7", pr, 0);
        step(pc_for(7'd9), 1'b0, 1'b0, pr);
        chk(pr == 1'b1, "R4", pr, 1);
    endtask

    task automatic t_hist();
        bit pr;
        bit outs [4];
        outs = '{1,0,1,1};
        do_reset();
        for (int s = 0; s < 4; s++) step(32'h0, 1'b1, outs[s], pr);
        step(32'h0, 1'b0, 1'b0, pr);
        chk(pred_idx == 7'b0001011, "R6", pred_idx, 11);
    endtask

    task automatic t_idle();
        bit pr;
        logic [6:0] h0;
        do_reset();
        step(32'h4, 1'b1, 1'b1, pr);
        h0 = m_hist;
        @(negedge clk);
        res_valid = 1'b0; res_taken = 1'b1; res_idx = 7'd20;
        repeat (5) @(posedge clk);
        step(32'h0, 1'b0, 1'b0, pr);
        chk(pred_idx == h0, "R11", pred_idx, h0);
        step(pc_for(7'd20), 1'b0, 1'b0, pr);
        chk(pr == 1'b0, "R11", pr, 0);
    endtask

    task automatic t_same();
        bit pr;
        do_reset();
        step(pc_for(7'd40), 1'b1, 1'b1, pr);
        chk(pr == 1'b0, "R8", pr, 0);
        step(pc_for(7'd40), 1'b0, 1'b0, pr);
        chk(pr == 1'b1, "R8", pr, 1);
    endtask

    task automatic t_alias();
        bit pr;
        logic [6:0] ia;
        do_reset();
        step(pc_for(7'd33), 1'b1, 1'b1, pr);
        step(pc_for(7'd33) + 32'h200, 1'b0, 1'b0, pr);
        ia = pred_idx;
        chk(pr == 1'b1, "R9", pr, 1);
        chk(ia == 7'd33, "R9", ia, 33);
    endtask

    task automatic t_loop();
        bit pr;
        bit tk;
        int miss;
        do_reset();
        for (int s = 0; s < 28; s++) step(32'h1000, 1'b1, (s % 7) != 6, pr);
        miss = 0;
        for (int s = 0; s < 21; s++) begin
            tk = (s % 7) != 6;
            step(32'h1000, 1'b1, tk, pr);
            if (pr != tk) miss++;
        end
        chk(miss == 0, "R10", miss, 0);
    endtask

    initial begin
        #2_000_000;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        t_walk();
        t_neighbor();
        t_hist();
        t_idle();
        t_same();
        t_alias();
        t_loop();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule